// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Macrocell

This block is one output slice of a small programmable logic fabric. A programmable AND plane forms nine product terms over a shared set of array inputs. Eight of them are ORed into a sum. The ninth is reserved for the output enable. An output stage then shapes the sum according to a three-bit configuration word. One bit chooses between a clocked register and a direct path. One bit sets the polarity. One bit chooses where the pad enable comes from: the cell's own enable term, or a shared active-low enable pin.

The array sees the external inputs plus one feedback bit from this cell, placed at the highest index. In the direct mode the feedback is the value present on the pad, which lets the slice act as a bidirectional pin. In the registered mode the feedback is the register state. A test preload port can force the register to a chosen value. A synchronous reset clears the register.

Top module: `mc_sop_cell`

## Requirements
- R1: Each link between a product term and an array input is a 2-bit code: 2'b00 ignores the input, 2'b01 uses the input true, 2'b10 uses it inverted, and 2'b11 (the erased state) forces that term to 0. Term t, input i sits at link_map[(t*(N_EXT+1)+i)*2 +: 2]. Terms 0..7 feed the sum and term 8 is the enable term.
- R2: A product term whose links are all 2'b00 evaluates to 1.
- R3: The sum is the OR of product terms 0..7.
- R4: With cfg[0]=1 (registered), pad_out reflects only the register, which is loaded at the rising clock edge. Input changes between edges do not move pad_out.
- R5: With cfg[0]=0 (direct), pad_out follows the sum within the same cycle.
- R6: cfg[1]=1 drives the value unchanged (active high). cfg[1]=0 drives its inverse (active low).
- R7: With cfg[2]=0, pad_oe equals product term 8. With cfg[2]=1, pad_oe is the inverse of oe_pin_n.
- R8: Array input N_EXT is the feedback bit fb. fb equals pad_in when cfg[0]=0 and the register state when cfg[0]=1, in which case pad_in has no effect.
- R9: When pl_en is 1 at a rising edge, the register loads pl_val instead of the sum.
- R10: When rst is 1 at a rising edge, the register becomes 0, even if pl_en is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the register |
| cfg | input | 3 | [0] registered, [1] active high, [2] enable from pin |
| arr_in | input | N_EXT | External array inputs |
| link_map | input | 2*(N_EXT+1)*(N_SUM+1) | Link codes for every term and input |
| oe_pin_n | input | 1 | Shared active-low enable pin |
| pad_in | input | 1 | Value seen on the pad |
| pl_en | input | 1 | Test preload strobe |
| pl_val | input | 1 | Test preload value |
| pad_out | output | 1 | Pad drive value |
| pad_oe | output | 1 | Pad drive enable |
| fb | output | 1 | Feedback bit returned to the array |

## Verification
The register can be asked to load the preload value and capture the sum at the same edge, and reset can fall on that same edge too. The bench provokes this in two ways. It sets up a sum opposite to pl_val and raises pl_en. It also raises rst together with pl_en. The register state is then read out through pad_out in registered mode on the following cycle and compared against a software model, which gives reset priority over preload and preload priority over capture.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {
    LNK_OPEN   = 2'b00,
    LNK_TRUE   = 2'b01,
    LNK_COMP   = 2'b10,
    LNK_ERASED = 2'b11
  } link_e;

  typedef struct packed {
    logic oe_from_pin;
    logic act_high;
    logic registered;
  } cell_cfg_t;

  localparam int LINK_W = 2;
endpackage

// File: rtl/mc_pterm.sv
module mc_pterm
  import mc_pkg::*;
#(
  parameter int N_ARR = 9
) (
  input  logic [N_ARR-1:0]        arr,
  input  logic [LINK_W*N_ARR-1:0] links,
  output logic                    term
);
  logic [N_ARR-1:0] lit_ok;

  genvar i;
  generate
    for (i = 0; i < N_ARR; i++) begin : g_lit
      link_e lk;
      assign lk = link_e'(links[LINK_W*i +: LINK_W]);
      always_comb begin
        case (lk)
          LNK_OPEN: lit_ok[i] = 1'b1;
          LNK_TRUE: lit_ok[i] = arr[i];
          LNK_COMP: lit_ok[i] = ~arr[i];
          default:  lit_ok[i] = 1'b0;
        endcase
      end
    end
  endgenerate

  assign term = &lit_ok;
endmodule

// File: rtl/mc_plane.sv
module mc_plane
  import mc_pkg::*;
#(
  parameter int N_ARR = 9,
  parameter int N_SUM = 8
) (
  input  logic [N_ARR-1:0]                    arr,
  input  logic [LINK_W*N_ARR*(N_SUM+1)-1:0]   link_map,
  output logic                                sum,
  output logic                                oe_term
);
  localparam int N_PT     = N_SUM + 1;
  localparam int LINKS_PT = LINK_W * N_ARR;

  logic [N_PT-1:0] terms;

  genvar t;
  generate
    for (t = 0; t < N_PT; t++) begin : g_term
      mc_pterm #(.N_ARR(N_ARR)) u_term (
        .arr   (arr),
        .links (link_map[t*LINKS_PT +: LINKS_PT]),
        .term  (terms[t])
      );
    end
  endgenerate

  assign sum     = |terms[N_SUM-1:0];
  assign oe_term = terms[N_SUM];
endmodule

// File: rtl/mc_outstage.sv
module mc_outstage
  import mc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  cell_cfg_t cfg,
  input  logic      sum,
  input  logic      oe_term,
  input  logic      oe_pin_n,
  input  logic      pad_in,
  input  logic      pl_en,
  input  logic      pl_val,
  output logic      pad_out,
  output logic      pad_oe,
  output logic      fb
);
  logic q;
  logic core;

  always_ff @(posedge clk) begin
    if (rst)        q <= 1'b0;
    else if (pl_en) q <= pl_val;
    else            q <= sum;
  end

  always_comb begin
    core    = cfg.registered ? q : sum;
    pad_out = cfg.act_high ? core : ~core;
    pad_oe  = cfg.oe_from_pin ? ~oe_pin_n : oe_term;
    fb      = cfg.registered ? q : pad_in;
  end

  // R10
  reset_clear_chk: assert property (@(posedge clk) $past(rst) |-> q == 1'b0);

  // R9
  preload_win_chk: assert property (@(posedge clk) disable iff (rst)
    pl_en |=> q == $past(pl_val));

  // R4
  reg_capture_chk: assert property (@(posedge clk) disable iff (rst)
    !pl_en |=> q == $past(sum));
endmodule

// File: rtl/mc_sop_cell.sv
module mc_sop_cell
  import mc_pkg::*;
#(
  parameter int N_EXT = 8,
  parameter int N_SUM = 8
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [2:0]                             cfg,
  input  logic [N_EXT-1:0]                       arr_in,
  input  logic [LINK_W*(N_EXT+1)*(N_SUM+1)-1:0]  link_map,
  input  logic                                   oe_pin_n,
  input  logic                                   pad_in,
  input  logic                                   pl_en,
  input  logic                                   pl_val,
  output logic                                   pad_out,
  output logic                                   pad_oe,
  output logic                                   fb
);
  localparam int N_ARR = N_EXT + 1;

  cell_cfg_t        cfg_s;
  logic [N_ARR-1:0] arr;
  logic             sum;
  logic             oe_term;

  assign cfg_s = cell_cfg_t'(cfg);
  assign arr   = {fb, arr_in};

  mc_plane #(.N_ARR(N_ARR), .N_SUM(N_SUM)) u_plane (
    .arr      (arr),
    .link_map (link_map),
    .sum      (sum),
    .oe_term  (oe_term)
  );

  mc_outstage u_out (
    .clk      (clk),
    .rst      (rst),
    .cfg      (cfg_s),
    .sum      (sum),
    .oe_term  (oe_term),
    .oe_pin_n (oe_pin_n),
    .pad_in   (pad_in),
    .pl_en    (pl_en),
    .pl_val   (pl_val),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .fb       (fb)
  );

  // R8
  fb_source_chk: assert property (@(posedge clk) disable iff (rst)
    cfg[0] |-> fb == (cfg[1] ? pad_out : ~pad_out));
endmodule

// File: tb/tb_mc_sop_cell.sv
`timescale 1ns/1ps
module tb_mc_sop_cell;
  localparam int N_EXT = 8;
  localparam int N_SUM = 8;
  localparam int N_ARR = N_EXT + 1;
  localparam int N_PT  = N_SUM + 1;
  localparam int MAP_W = 2 * N_ARR * N_PT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cfg = 3'b011;
  logic [N_EXT-1:0] arr_in = '0;
  logic [MAP_W-1:0] link_map = '1;
  logic oe_pin_n = 1'b1;
  logic pad_in = 1'b0;
  logic pl_en = 1'b0;
  logic pl_val = 1'b0;
  logic pad_out, pad_oe, fb;

  always #4 clk = ~clk;

  mc_sop_cell #(.N_EXT(N_EXT), .N_SUM(N_SUM)) dut (
    .clk(clk), .rst(rst), .cfg(cfg), .arr_in(arr_in), .link_map(link_map),
    .oe_pin_n(oe_pin_n), .pad_in(pad_in), .pl_en(pl_en), .pl_val(pl_val),
    .pad_out(pad_out), .pad_oe(pad_oe), .fb(fb)
  );

  typedef struct {
    logic  po;
    logic  oe;
    logic  fbv;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  event ev_sample;
  int   n_cmp = 0;
  int   n_bad = 0;
  logic model_q = 1'b0;
  bit   done = 1'b0;

  function automatic logic m_term(input logic [MAP_W-1:0] m, input int t,
                                  input logic [N_ARR-1:0] v);
    logic r = 1'b1;
    for (int i = 0; i < N_ARR; i++) begin
      case (m[(t*N_ARR+i)*2 +: 2])
        2'b01: r = r & v[i];
        2'b10: r = r & ~v[i];
        2'b11: r = 1'b0;
        default: ;
      endcase
    end
    return r;
  endfunction

  task automatic set_link(input int t, input int i, input logic [1:0] code);
    link_map[(t*N_ARR+i)*2 +: 2] = code;
  endtask

  task automatic open_term(input int t);
    for (int i = 0; i < N_ARR; i++) set_link(t, i, 2'b00);
  endtask

  // Driver: inputs were set after the last edge; sample at the falling edge.
  task automatic step(input string tag);
    exp_t e;
    logic fbm, s, oet, core, nq;
    logic [N_ARR-1:0] v;
    @(negedge clk);
    fbm = cfg[0] ? model_q : pad_in;
    v = {fbm, arr_in};
    s = 1'b0;
    for (int t = 0; t < N_SUM; t++) s = s | m_term(link_map, t, v);
    oet = m_term(link_map, N_SUM, v);
    core = cfg[0] ? model_q : s;
    e.po = cfg[1] ? core : ~core;
    e.oe = cfg[2] ? ~oe_pin_n : oet;
    e.fbv = fbm;
    e.tag = tag;
    nq = rst ? 1'b0 : (pl_en ? pl_val : s);
    exp_q.push_back(e);
    ->ev_sample;
    @(posedge clk);
    model_q = nq;
    #1;
  endtask

  // Monitor
  initial begin
    forever begin
      exp_t e;
      @(ev_sample);
      e = exp_q.pop_front();
      n_cmp++;
      if (pad_out !== e.po || pad_oe !== e.oe || fb !== e.fbv) begin
        n_bad++;
        $display("FAIL %s: actual out/oe/fb=%b%b%b expected=%b%b%b",
                 e.tag, pad_out, pad_oe, fb, e.po, e.oe, e.fbv);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    // R10: reset state, registered active high
    step("R10");
    pl_en = 1'b1; pl_val = 1'b1;
    step("R10");
    rst = 1'b0; pl_en = 1'b0;
    step("R10");
    // R1: erased array gives 0 sum, polarity both ways (R6)
    cfg = 3'b010; step("R1");
    cfg = 3'b000; step("R6");
    // R1: true and complement links
    cfg = 3'b010;
    set_link(0, 0, 2'b01); set_link(0, 1, 2'b10);
    for (int i = 2; i < N_ARR; i++) set_link(0, i, 2'b00);
    arr_in = 8'b0000_0001; step("R1");
    arr_in = 8'b0000_0011; step("R1");
    arr_in = 8'b0000_0000; step("R1");
    // R2: fully open term, and open enable term (R7)
    link_map = '1; open_term(0); step("R2");
    open_term(N_SUM); step("R7");
    // R7: pin source
    cfg = 3'b110; oe_pin_n = 1'b0; step("R7");
    oe_pin_n = 1'b1; step("R7");
    // R3: each term alone sets the sum
    for (int t = 0; t < N_SUM; t++) begin
      link_map = '1; open_term(t); step("R3");
    end
    // R8: feedback from pad in direct mode
    link_map = '1; cfg = 3'b010;
    for (int i = 0; i < N_ARR; i++) set_link(0, i, 2'b00);
    set_link(0, N_EXT, 2'b01);
    pad_in = 1'b1; step("R8");
    pad_in = 1'b0; step("R8");
    // R4/R5: mid-cycle change of the array
    link_map = '1; open_term(0); cfg = 3'b011; step("R4");
    link_map = '1; step("R4");
    step("R4");
    cfg = 3'b010; open_term(0); step("R5");
    link_map = '1; step("R5");
    // R8: pad_in ignored in registered mode
    cfg = 3'b011; pad_in = 1'b1; step("R8");
    pad_in = 1'b0; step("R8");
    // R9: preload against an opposite sum
    open_term(0); pl_en = 1'b1; pl_val = 1'b0; step("R9");
    pl_en = 1'b0; link_map = '1; step("R9");
    pl_en = 1'b1; pl_val = 1'b1; step("R9");
    pl_en = 1'b0; step("R9");
    // R10: reset beats preload
    rst = 1'b1; pl_en = 1'b1; pl_val = 1'b1; step("R10");
    rst = 1'b0; pl_en = 1'b0; step("R10");
    // Random sweep over all configurations
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 40; k++) begin
        cfg = 3'(c);
        for (int b = 0; b < MAP_W / 2; b++) begin
          int r = $urandom_range(0, 99);
          link_map[b*2 +: 2] = (r < 75) ? 2'b00 : (r < 87) ? 2'b01 :
                               (r < 99) ? 2'b10 : 2'b11;
        end
        arr_in   = 8'($urandom);
        pad_in   = 1'($urandom);
        oe_pin_n = 1'($urandom);
        pl_en    = ($urandom_range(0, 7) == 0);
        pl_val   = 1'($urandom);
        rst      = ($urandom_range(0, 19) == 0);
        step("R3");
      end
    end
    rst = 1'b0; pl_en = 1'b0; link_map = '1;
    step("R1");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule